// File: doc/BRIEF.md
# Locality access request controller

This block is a host-side sequencer for the one-byte access register that a trusted-module FIFO interface keeps for each locality. Software, or a higher-level controller, gives it one command: request a locality, release a locality, or wait for a grant. It also names the locality number. The block then runs the whole register dialogue by itself on a simple read/write master port and reports a single status code with a one-cycle done pulse.

A register read counts only when the register's valid flag is set. An invalid read is retried after a programmable quiet interval (timeout A, a cycle count that would normally stand for 750 ms). After the third invalid read the command gives up with a timeout. A request is refused when a request is already pending or the locality already owns the module. A release is performed by writing the active-locality flag back to the register. A wait checks once, pauses one timeout-A interval if a request is outstanding, and checks again. A bus error on any cycle ends the command at once.

Top module: `loc_access_seq`

## Requirements
- R1: `cmd_ready` is high only in idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high, and `cmd_ready` is low in the next cycle. While a command runs, `cmd_valid` has no effect: it starts no bus cycle and produces no extra done pulse.
- R2: An access read is accepted only when bit 7 (valid) of the returned byte is 1. Each invalid read is followed by at least `TIMEOUT_CYC` cycles without a bus request before the next read. After three invalid reads in a row the command ends with status 3 (timed out).
- R3: Op 0 (request) on a valid read: bit 1 (request pending) set gives status 2 (unavailable). Otherwise bit 5 (active) set gives status 1 (bad state). Otherwise the block writes 0x02 and ends with status 0 (ok).
- R4: Op 1 (release) on a valid read: bit 1 set or bit 5 clear gives status 1. Otherwise the block writes 0x20 and ends with status 0.
- R5: Op 2 (wait): bit 5 set gives status 0 with no further cycles. Bit 5 and bit 1 both clear gives status 1. Bit 1 set alone makes the block pause at least `TIMEOUT_CYC` cycles and do a second qualified read, which has its own three tries. On that second read, bit 5 gives 0, else bit 1 gives 3, else the result is 1.
- R6: A cycle answered with `bus_err` high ends the command in the next cycle with status 4 (bus error), and no further bus cycle follows.
- R7: `done` is a single-cycle pulse. `status` is valid while `done` is high. Exactly one pulse follows each accepted command.
- R8: Every bus cycle carries the locality given with the command. A write carries only 0x02 or 0x20.
- R9: `bus_req` stays high, with `bus_we`, `bus_wdata` and `bus_loc` unchanged, until the cycle in which `bus_ack` is high. No bus cycle occurs outside a command.
- R10: Op 3 is illegal. It ends with status 1 and no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 request, 1 release, 2 wait, 3 illegal |
| cmd_loc | input | LOC_W | Locality number |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 bad state, 2 unavailable, 3 timed out, 4 bus error |
| bus_req | output | 1 | Register cycle request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_loc | output | LOC_W | Locality whose access register is addressed |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | Cycle completed |
| bus_rdata | input | 8 | Read byte, valid with `bus_ack` |
| bus_err | input | 1 | Cycle failed, valid with `bus_ack` |

## Verification
On every cycle, the assertions check the bus handshake hold, the legal write bytes, the rule that no request appears while the interval timer runs, the single-cycle done pulse, the drop of ready after acceptance, the status that follows a bus error, and the bound on the retry counter. Which status each register pattern produces can only be shown by the bench's scenarios. The same goes for the retry count of three, the two-read sequence of a wait, and the fact that a busy-time command is ignored. Its reference model predicts the bus cycles and final code of each command, and it checks them cycle by cycle.

// File: rtl/loc_acc_pkg.sv
package loc_acc_pkg;

  localparam int unsigned ACC_W = 8;

  // bit positions the sequencer decodes in the access byte
  localparam int unsigned VALID_POS  = 7;
  localparam int unsigned ACTIVE_POS = 5;
  localparam int unsigned PEND_POS   = 1;

  localparam logic [ACC_W-1:0] WR_ASK  = 8'h02;
  localparam logic [ACC_W-1:0] WR_DROP = 8'h20;

  typedef enum logic [1:0] {
    OP_ASK  = 2'd0,
    OP_DROP = 2'd1,
    OP_WAIT = 2'd2,
    OP_ILL  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RC_OK      = 3'd0,
    RC_BAD     = 3'd1,
    RC_BUSY    = 3'd2,
    RC_TIMEOUT = 3'd3,
    RC_BUSERR  = 3'd4
  } rc_e;

  typedef enum logic [1:0] {
    ACT_FINISH = 2'd0,
    ACT_WRITE  = 2'd1,
    ACT_PAUSE  = 2'd2
  } act_e;

  typedef struct packed {
    act_e             kind;
    rc_e              code;
    logic [ACC_W-1:0] wbyte;
  } action_t;

  function automatic logic byte_valid(input logic [ACC_W-1:0] v);
    return v[VALID_POS];
  endfunction

  // what to do after a qualified read of the access byte
  function automatic action_t decide(input op_e op, input logic second,
                                     input logic [ACC_W-1:0] v);
    action_t a;
    a.kind  = ACT_FINISH;
    a.code  = RC_BAD;
    a.wbyte = '0;
    unique case (op)
      OP_ASK: begin
        if (v[PEND_POS])        a.code = RC_BUSY;
        else if (v[ACTIVE_POS]) a.code = RC_BAD;
        else begin
          a.kind  = ACT_WRITE;
          a.code  = RC_OK;
          a.wbyte = WR_ASK;
        end
      end
      OP_DROP: begin
        if (v[PEND_POS] || !v[ACTIVE_POS]) a.code = RC_BAD;
        else begin
          a.kind  = ACT_WRITE;
          a.code  = RC_OK;
          a.wbyte = WR_DROP;
        end
      end
      OP_WAIT: begin
        if (v[ACTIVE_POS])    a.code = RC_OK;
        else if (second)      a.code = v[PEND_POS] ? RC_TIMEOUT : RC_BAD;
        else if (v[PEND_POS]) a.kind = ACT_PAUSE;
        else                  a.code = RC_BAD;
      end
      default: a.code = RC_BAD;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/loc_acc_timer.sv
module loc_acc_timer #(
  parameter int unsigned TIMEOUT_CYC = 75_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expired
);
  localparam int unsigned CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= LOAD;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy    = busy_q;
  assign expired = busy_q && (cnt_q == '0);

  // R2
  start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/loc_acc_tries.sv
module loc_acc_tries #(
  parameter int unsigned READ_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned TRY_W = (READ_TRIES > 1) ? $clog2(READ_TRIES) : 1;
  localparam logic [TRY_W-1:0] TOP = TRY_W'(READ_TRIES - 1);

  logic [TRY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clr)                 cnt_q <= '0;
    else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == TOP);

  // R2
  tries_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);

endmodule

// File: rtl/loc_access_seq.sv
module loc_access_seq
  import loc_acc_pkg::*;
#(
  parameter int unsigned LOC_W       = 3,
  parameter int unsigned TIMEOUT_CYC = 75_000_000,
  parameter int unsigned READ_TRIES  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LOC_W-1:0] cmd_loc,
  output logic             done,
  output logic [2:0]       status,
  output logic             bus_req,
  output logic             bus_we,
  output logic [LOC_W-1:0] bus_loc,
  output logic [7:0]       bus_wdata,
  input  logic             bus_ack,
  input  logic [7:0]       bus_rdata,
  input  logic             bus_err
);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_GAP, S_EVAL, S_PAUSE, S_WRITE
  } state_e;

  state_e           st_q, st_d;
  op_e              op_q;
  logic [LOC_W-1:0] loc_q;
  logic             second_q;
  logic [ACC_W-1:0] val_q;
  logic [ACC_W-1:0] wbyte_q;
  logic             done_q;
  rc_e              code_q;

  // named internal events
  logic    accept;
  logic    rd_good;
  logic    rd_stale;
  logic    tries_last;
  logic    tmr_start, tmr_busy, tmr_exp;
  logic    try_clr, try_inc;
  logic    fin;
  rc_e     fin_code;
  action_t act;

  loc_acc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .busy    (tmr_busy),
    .expired (tmr_exp)
  );

  loc_acc_tries #(.READ_TRIES(READ_TRIES)) u_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (try_clr),
    .inc   (try_inc),
    .last  (tries_last)
  );

  assign accept   = (st_q == S_IDLE) && cmd_valid;
  assign rd_good  = (st_q == S_READ) && bus_ack && !bus_err && byte_valid(bus_rdata);
  assign rd_stale = (st_q == S_READ) && bus_ack && !bus_err && !byte_valid(bus_rdata);
  assign act      = decide(op_q, second_q, val_q);

  always_comb begin
    st_d      = st_q;
    fin       = 1'b0;
    fin_code  = RC_OK;
    tmr_start = 1'b0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (cmd_valid) begin
          try_clr = 1'b1;
          st_d    = (op_e'(cmd_op) == OP_ILL) ? S_EVAL : S_READ;
        end
      end
      S_READ: begin
        if (bus_ack) begin
          if (bus_err) begin
            fin      = 1'b1;
            fin_code = RC_BUSERR;
          end else if (rd_good) begin
            st_d = S_EVAL;
          end else if (tries_last) begin
            fin      = 1'b1;
            fin_code = RC_TIMEOUT;
          end else begin
            try_inc   = 1'b1;
            tmr_start = 1'b1;
            st_d      = S_GAP;
          end
        end
      end
      S_GAP: begin
        if (tmr_exp) st_d = S_READ;
      end
      S_EVAL: begin
        unique case (act.kind)
          ACT_WRITE: st_d = S_WRITE;
          ACT_PAUSE: begin
            tmr_start = 1'b1;
            try_clr   = 1'b1;
            st_d      = S_PAUSE;
          end
          default: begin
            fin      = 1'b1;
            fin_code = act.code;
          end
        endcase
      end
      S_PAUSE: begin
        if (tmr_exp) st_d = S_READ;
      end
      S_WRITE: begin
        if (bus_ack) begin
          fin      = 1'b1;
          fin_code = bus_err ? RC_BUSERR : RC_OK;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_ASK;
      loc_q    <= '0;
      second_q <= 1'b0;
      val_q    <= '0;
      wbyte_q  <= '0;
      done_q   <= 1'b0;
      code_q   <= RC_OK;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (fin) code_q <= fin_code;
      if (accept) begin
        op_q     <= op_e'(cmd_op);
        loc_q    <= cmd_loc;
        second_q <= 1'b0;
        val_q    <= '0;
      end
      if (rd_good) val_q <= bus_rdata;
      if (st_q == S_EVAL && act.kind == ACT_WRITE) wbyte_q <= act.wbyte;
      if (st_q == S_EVAL && act.kind == ACT_PAUSE) second_q <= 1'b1;
    end
  end

  assign cmd_ready = (st_q == S_IDLE);
  assign done      = done_q;
  assign status    = code_q;
  assign bus_req   = (st_q == S_READ) || (st_q == S_WRITE);
  assign bus_we    = (st_q == S_WRITE);
  assign bus_loc   = loc_q;
  assign bus_wdata = (st_q == S_WRITE) ? wbyte_q : '0;

  // R1
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !bus_req);

  // R6
  err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> (done && status == 3'd4 && !bus_req));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  write_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == 8'h02 || bus_wdata == 8'h20));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                               $stable(bus_wdata) && $stable(bus_loc)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req);

endmodule

// File: tb/sim_loc_access_seq.sv
module sim_loc_access_seq;
  localparam int CLK_PERIOD = 10;
  localparam int T_CYC      = 20;
  localparam int LW         = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [LW-1:0] cmd_loc = '0;
  logic          done;
  logic [2:0]    status;
  logic          bus_req, bus_we;
  logic [LW-1:0] bus_loc;
  logic [7:0]    bus_wdata;
  logic          bus_ack = 1'b0;
  logic [7:0]    bus_rdata = '0;
  logic          bus_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loc_access_seq #(.LOC_W(LW), .TIMEOUT_CYC(T_CYC), .READ_TRIES(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_loc(cmd_loc), .done(done), .status(status),
    .bus_req(bus_req), .bus_we(bus_we), .bus_loc(bus_loc),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  int checks = 0;
  int errors = 0;

  // scripted slave answers, one per bus cycle
  logic [7:0]    scr_data[$];
  logic          scr_err[$];
  // expected bus cycles from the reference model
  logic          exp_we[$];
  logic [7:0]    exp_wd[$];
  logic [LW-1:0] cur_loc = '0;
  logic          first_txn = 1'b1;
  logic          prev_we = 1'b0;
  int            cyc = 0;
  int            last_ack = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add(input logic [7:0] d, input logic e);
    scr_data.push_back(d);
    scr_err.push_back(e);
  endtask

  // slave and per-cycle monitor
  always @(negedge clk) begin
    cyc++;
    if (bus_req && !bus_ack) begin
      if (exp_we.size() == 0) begin
        check(1'b0, "R9", "unexpected bus cycle", 1, 0);
      end else begin
        logic ew;
        logic [7:0] ed;
        ew = exp_we.pop_front();
        ed = exp_wd.pop_front();
        check(bus_we === ew, "R8", "cycle direction", int'(bus_we), int'(ew));
        if (ew) check(bus_wdata === ed, "R8", "write byte", bus_wdata, ed);
        check(bus_loc === cur_loc, "R8", "bus locality", bus_loc, cur_loc);
      end
      if (!bus_we && !first_txn && !prev_we)
        check(cyc - last_ack >= T_CYC, "R2", "gap before reread",
              cyc - last_ack, T_CYC);
      first_txn = 1'b0;
      prev_we   = bus_we;
      last_ack  = cyc;
      bus_ack   = 1'b1;
      if (scr_data.size() > 0) begin
        bus_rdata = scr_data.pop_front();
        bus_err   = scr_err.pop_front();
      end else begin
        bus_rdata = 8'h00;
        bus_err   = 1'b0;
      end
    end else begin
      bus_ack   = 1'b0;
      bus_err   = 1'b0;
      bus_rdata = 8'h00;
    end
  end

  // reference model: walks the script, queues expected cycles, returns code
  task automatic predict(input int op, output int rc);
    int i;
    bit second;
    bit got;
    logic [7:0] v;
    i = 0;
    second = 0;
    v = 0;
    if (op == 3) begin
      rc = 1;
      return;
    end
    while (1) begin
      got = 0;
      for (int t = 0; t < 3; t++) begin
        exp_we.push_back(1'b0);
        exp_wd.push_back(8'h00);
        if (scr_err[i]) begin
          rc = 4;
          return;
        end
        v = scr_data[i];
        i++;
        if (v[7]) begin
          got = 1;
          break;
        end
      end
      if (!got) begin
        rc = 3;
        return;
      end
      if (op == 0) begin
        if (v[1])      rc = 2;
        else if (v[5]) rc = 1;
        else begin
          exp_we.push_back(1'b1);
          exp_wd.push_back(8'h02);
          rc = scr_err[i] ? 4 : 0;
        end
        return;
      end
      if (op == 1) begin
        if (v[1] || !v[5]) rc = 1;
        else begin
          exp_we.push_back(1'b1);
          exp_wd.push_back(8'h20);
          rc = scr_err[i] ? 4 : 0;
        end
        return;
      end
      if (v[5]) begin
        rc = 0;
        return;
      end
      if (second) begin
        rc = v[1] ? 3 : 1;
        return;
      end
      if (!v[1]) begin
        rc = 1;
        return;
      end
      second = 1;
    end
  endtask

  task automatic run_cmd(input int op, input int loc, input bit poke,
                         input string req);
    int rc;
    int n;
    predict(op, rc);
    cur_loc   = LW'(loc);
    first_txn = 1'b1;
    prev_we   = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_loc   = LW'(loc);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R1", "ready after take", cmd_ready, 0);
    n = 0;
    while (!done && n < 3000) begin
      if (poke && n == 4) begin
        cmd_valid = 1'b1;
        cmd_op    = 2'd0;
        cmd_loc   = LW'(loc + 1);
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    cmd_valid = 1'b0;
    check(done == 1'b1, req, "done seen", done, 1);
    check(int'(status) == rc, req, "status code", status, rc);
    check(exp_we.size() == 0, req, "cycles left unissued", exp_we.size(), 0);
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", done, 0);
    exp_we.delete();
    exp_wd.delete();
    scr_data.delete();
    scr_err.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    check(done == 1'b0, "R7", "reset done", done, 0);
    check(bus_req == 1'b0, "R9", "reset bus idle", bus_req, 0);

    // R3 request paths
    add(8'h80, 0); add(8'h00, 0);      run_cmd(0, 1, 0, "R3");
    add(8'h82, 0);                     run_cmd(0, 2, 0, "R3");
    add(8'hA0, 0);                     run_cmd(0, 3, 0, "R3");
    add(8'hA2, 0);                     run_cmd(0, 0, 0, "R3");
    // R2 retries
    add(8'h00, 0); add(8'h20, 0); add(8'h80, 0); add(8'h00, 0);
    run_cmd(0, 4, 0, "R2");
    add(8'h02, 0); add(8'h00, 0); add(8'h7F, 0);
    run_cmd(1, 5, 0, "R2");
    // R4 release paths
    add(8'hA0, 0); add(8'h00, 0);      run_cmd(1, 6, 0, "R4");
    add(8'h80, 0);                     run_cmd(1, 7, 0, "R4");
    add(8'hA2, 0);                     run_cmd(1, 1, 0, "R4");
    // R5 wait paths
    add(8'hA0, 0);                     run_cmd(2, 2, 0, "R5");
    add(8'h80, 0);                     run_cmd(2, 3, 0, "R5");
    add(8'h82, 0); add(8'hA0, 0);      run_cmd(2, 4, 0, "R5");
    add(8'h82, 0); add(8'h82, 0);      run_cmd(2, 5, 0, "R5");
    add(8'h82, 0); add(8'h80, 0);      run_cmd(2, 6, 0, "R5");
    add(8'h82, 0); add(8'h00, 0); add(8'h00, 0); add(8'hA0, 0);
    run_cmd(2, 7, 0, "R5");
    // R6 bus errors on read and on write
    add(8'h80, 1);                     run_cmd(0, 1, 0, "R6");
    add(8'h80, 0); add(8'h00, 1);      run_cmd(0, 2, 0, "R6");
    add(8'h00, 0); add(8'h00, 1);      run_cmd(2, 3, 0, "R6");
    // R10 illegal op
    run_cmd(3, 4, 0, "R10");
    // R1 a command offered while busy is ignored
    add(8'h82, 0); add(8'hA0, 0);      run_cmd(2, 5, 1, "R1");
    repeat (40) @(negedge clk);
    check(done == 1'b0, "R1", "no extra done", done, 0);
    check(cmd_ready == 1'b1, "R1", "idle after ignored offer", cmd_ready, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule